// File: doc/BRIEF.md
# Read Latency and Byte Mask Data Path

This block sits between a memory array and a 16-bit bidirectional data bus. Each cycle it may receive a read strobe with the array word that goes with it. It holds that word for a programmed number of cycles and then drives it onto the bus with per-byte output enables. A write strobe passes the bus input straight through to the array with per-byte write enables. The same two byte-mask bits act on both directions. In reads they switch off a lane's drivers two cycles later. In writes they block that lane in the same cycle.

A read may arrive on every cycle, so the delay line keeps one entry per cycle and a burst streams with no gaps. A write strobe discards any read words still in flight, so the bus is never driven while data comes in. A halt strobe (precharge or burst stop) admits no new read, and the bus falls idle once the words already queued have left.

Top module: `dq_lat_path`

## Requirements
- R1: A word sampled on `arr_rdata` with an accepted read strobe at edge n is on `bus_dout`, with its lanes enabled, from edge n+L-1 until edge n+L, where L is `cfg_lat` (1, 2 or 3) and a `cfg_lat` of 0 acts as 1.
- R2: Read strobes on consecutive cycles give consecutive bus words with no idle cycle between them, in strobe order.
- R3: A set `byte_mask` bit sampled at edge n disables its read lane from edge n+1 until edge n+2. Bit 1 controls `bus_dout[15:8]` and `bus_oe[1]`; bit 0 controls `bus_dout[7:0]` and `bus_oe[0]`. A lane whose enable is low reads as zero on `bus_dout`.
- R4: While `wr_strb` is high, `arr_we[b]` equals the inverse of `byte_mask[b]` in the same cycle, and `arr_wdata` equals `bus_din`. With `wr_strb` low, both `arr_we` bits are low.
- R5: While `wr_strb` is high, both `bus_oe` bits are low. A write strobe discards every read word still in flight, and a read strobe in the same cycle is ignored.
- R6: A read strobe in a cycle with `halt_strb` high is ignored. Words from reads accepted before the halt still appear, so after a halt at edge n the bus is idle by edge n+L at the latest (at most 3 cycles).
- R7: While reset is asserted, `bus_oe` is zero and `bus_dout` is zero, even with read strobes present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_lat | input | 2 | Programmed read latency in cycles (0 treated as 1) |
| rd_strb | input | 1 | Read strobe; `arr_rdata` is valid in this cycle |
| wr_strb | input | 1 | Write strobe; `bus_din` is taken in this cycle |
| halt_strb | input | 1 | Precharge or burst stop; blocks a read in the same cycle |
| byte_mask | input | 2 | Byte masks, bit 1 upper byte, bit 0 lower byte |
| arr_rdata | input | 16 | Read word from the array |
| bus_din | input | 16 | Write word from the bus |
| bus_dout | output | 16 | Word driven onto the bus |
| bus_oe | output | 2 | Per-byte output enable of the bus drivers |
| arr_we | output | 2 | Per-byte write enable toward the array |
| arr_wdata | output | 16 | Write word toward the array |

## Verification
The bench builds the block with its default parameters: a 16-bit word in two 8-bit lanes, a three-stage delay line and a two-stage mask delay. It sweeps `cfg_lat` over 0, 1, 2 and 3 at run time, so the clamped setting and every stage tap of the delay line are reached. The directed sequences line up the two-cycle read mask against streaming reads, a write landing right after reads at the shortest and longest latencies, and halts at every latency. These show where the last driven cycle falls in each case.

// File: rtl/dq_pkg.sv
package dq_pkg;

  // Index of the delay-line tap for a programmed latency; 0 acts as 1,
  // values above the line depth saturate at the last stage.
  function automatic int unsigned tap_of(input int unsigned cfg,
                                         input int unsigned depth);
    if (cfg == 0)
      return 0;
    else if (cfg > depth)
      return depth - 1;
    else
      return cfg - 1;
  endfunction

endpackage

// File: rtl/dq_rd_pipe.sv
module dq_rd_pipe #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 3,
  localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              flush,
  input  logic [DATA_W-1:0] din,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] dout,
  output logic              dvld
);

  logic [DEPTH-1:0]             vld_q, vld_d;
  logic [DEPTH-1:0][DATA_W-1:0] dat_q, dat_d;
  logic [DEPTH-1:0]             dat_en;

  always_comb begin
    vld_d[0]  = push & ~flush;
    dat_d[0]  = din;
    dat_en[0] = push;
    for (int j = 1; j < DEPTH; j++) begin
      vld_d[j]  = vld_q[j-1] & ~flush;
      dat_d[j]  = dat_q[j-1];
      dat_en[j] = vld_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      for (int j = 0; j < DEPTH; j++) begin
        if (dat_en[j]) dat_q[j] <= dat_d[j];
      end
    end
  end

  assign dout = dat_q[sel];
  assign dvld = vld_q[sel];

endmodule

// File: rtl/dq_mask_dly.sv
module dq_mask_dly #(
  parameter int unsigned LANES = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] mask_in,
  output logic [LANES-1:0] mask_late
);

  logic [DEPTH-1:0][LANES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d[0] = mask_in;
    for (int j = 1; j < DEPTH; j++) chain_d[j] = chain_q[j-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign mask_late = chain_q[DEPTH-1];

endmodule

// File: rtl/dq_wr_gate.sv
module dq_wr_gate #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              wr_strb,
  input  logic [LANES-1:0]  byte_mask,
  input  logic [DATA_W-1:0] bus_din,
  output logic [LANES-1:0]  arr_we,
  output logic [DATA_W-1:0] arr_wdata
);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign arr_we[b] = wr_strb & ~byte_mask[b];
  end

  assign arr_wdata = bus_din;

endmodule

// File: rtl/dq_lat_path.sv
module dq_lat_path #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LANES    = 2,
  parameter int unsigned MAX_LAT  = 3,
  parameter int unsigned MASK_DLY = 2,
  parameter int unsigned LAT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic              rd_strb,
  input  logic              wr_strb,
  input  logic              halt_strb,
  input  logic [LANES-1:0]  byte_mask,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic [LANES-1:0]  bus_oe,
  output logic [LANES-1:0]  arr_we,
  output logic [DATA_W-1:0] arr_wdata
);

  localparam int unsigned LANE_W = DATA_W / LANES;
  localparam int unsigned SEL_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

  // reset: asserted at once, released after two clean edges
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic [SEL_W-1:0]  tap_sel;
  logic              rd_push;
  logic [DATA_W-1:0] pipe_dat;
  logic              pipe_vld;
  logic [LANES-1:0]  rd_mask_late;

  always_comb begin
    tap_sel = SEL_W'(dq_pkg::tap_of(int'(cfg_lat), MAX_LAT));
    rd_push = rd_strb & ~wr_strb & ~halt_strb;
  end

  dq_rd_pipe #(
    .DATA_W (DATA_W),
    .DEPTH  (MAX_LAT)
  ) u_pipe (
    .clk   (clk),
    .rst_n (core_rst_n),
    .push  (rd_push),
    .flush (wr_strb),
    .din   (arr_rdata),
    .sel   (tap_sel),
    .dout  (pipe_dat),
    .dvld  (pipe_vld)
  );

  dq_mask_dly #(
    .LANES (LANES),
    .DEPTH (MASK_DLY)
  ) u_mask (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .mask_in   (byte_mask),
    .mask_late (rd_mask_late)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_drv
    assign bus_oe[b] = pipe_vld & ~rd_mask_late[b] & ~wr_strb;
    assign bus_dout[b*LANE_W +: LANE_W] =
      bus_oe[b] ? pipe_dat[b*LANE_W +: LANE_W] : '0;
  end

  dq_wr_gate #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_wr (
    .wr_strb   (wr_strb),
    .byte_mask (byte_mask),
    .bus_din   (bus_din),
    .arr_we    (arr_we),
    .arr_wdata (arr_wdata)
  );

endmodule

// File: rtl/dq_lat_path_chk.sv
module dq_lat_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_lat,
  input logic        rd_strb,
  input logic        wr_strb,
  input logic        halt_strb,
  input logic [1:0]  byte_mask,
  input logic [15:0] arr_rdata,
  input logic [15:0] bus_din,
  input logic [15:0] bus_dout,
  input logic [1:0]  bus_oe,
  input logic [1:0]  arr_we,
  input logic [15:0] arr_wdata
);

  logic [2:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R5
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strb |-> (bus_oe == 2'b00));

  // R5
  wr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && $past(wr_strb)) |-> (bus_oe == 2'b00));

  // R3
  rmask_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && $past(byte_mask[0], 2)) |-> !bus_oe[0]);

  // R3
  rmask_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && $past(byte_mask[1], 2)) |-> !bus_oe[1]);

  // R4
  wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb && !byte_mask[1]) |-> arr_we[1]);

  // R4
  wblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mask[0] |-> !arr_we[0]);

  // R1
  lat1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd5 && cfg_lat == 2'd1 && $past(cfg_lat) == 2'd1 &&
     $past(rd_strb && !wr_strb && !halt_strb) && !wr_strb &&
     $past(byte_mask, 2) == 2'b00)
    |-> (bus_oe == 2'b11 && bus_dout == $past(arr_rdata)));

  // R6
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && cfg_lat == 2'd1 && $past(cfg_lat) == 2'd1 &&
     $past(halt_strb)) |-> (bus_oe == 2'b00));

endmodule

bind dq_lat_path dq_lat_path_chk u_chk (.*);

// File: tb/dq_lat_path_bench.sv
module dq_lat_path_bench;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_lat;
  logic        rd_strb, wr_strb, halt_strb;
  logic [1:0]  byte_mask;
  logic [15:0] arr_rdata, bus_din;
  logic [15:0] bus_dout;
  logic [1:0]  bus_oe;
  logic [1:0]  arr_we;
  logic [15:0] arr_wdata;

  int checks;
  int errors;
  bit done;

  dq_lat_path u_dq_lat_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_lat   (cfg_lat),
    .rd_strb   (rd_strb),
    .wr_strb   (wr_strb),
    .halt_strb (halt_strb),
    .byte_mask (byte_mask),
    .arr_rdata (arr_rdata),
    .bus_din   (bus_din),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe),
    .arr_we    (arr_we),
    .arr_wdata (arr_wdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // per-cycle stimulus of one scenario
  logic        s_rd   [64];
  logic        s_wr   [64];
  logic        s_halt [64];
  logic [1:0]  s_mask [64];

  task automatic clear_stim();
    for (int i = 0; i < 64; i++) begin
      s_rd[i] = 1'b0; s_wr[i] = 1'b0; s_halt[i] = 1'b0; s_mask[i] = 2'b00;
    end
  endtask

  // Drives n cycles of stimulus plus a drain, predicting every output.
  task automatic run_seq(input int n, input logic [1:0] lat, input string rq);
    logic        ev [80];
    logic [15:0] ed [80];
    logic [1:0]  mh [80];
    int L;
    L = (lat == 2'd0) ? 1 : int'(lat);
    for (int i = 0; i < 80; i++) begin ev[i] = 1'b0; ed[i] = '0; mh[i] = 2'b00; end
    cfg_lat = lat;
    for (int c = 0; c < n + 5; c++) begin
      logic        rd, wr, hl;
      logic [1:0]  mk, eoe, ewe;
      logic [15:0] rdat, wdat, edo;
      @(negedge clk);
      rd = (c < n) ? s_rd[c] : 1'b0;
      wr = (c < n) ? s_wr[c] : 1'b0;
      hl = (c < n) ? s_halt[c] : 1'b0;
      mk = (c < n) ? s_mask[c] : 2'b00;
      rdat = 16'(c * 16'h1357 + 16'h2468);
      wdat = ~rdat ^ 16'h00F0;
      rd_strb = rd; wr_strb = wr; halt_strb = hl; byte_mask = mk;
      arr_rdata = rdat; bus_din = wdat;
      mh[c] = mk;
      if (wr) for (int s = c; s < 80; s++) ev[s] = 1'b0;
      if (rd && !wr && !hl) begin ev[c+L] = 1'b1; ed[c+L] = rdat; end
      #1;
      for (int b = 0; b < 2; b++)
        eoe[b] = ev[c] && !wr && !((c >= 2) ? mh[c-2][b] : 1'b0);
      edo = {eoe[1] ? ed[c][15:8] : 8'h00, eoe[0] ? ed[c][7:0] : 8'h00};
      ewe = wr ? ~mk : 2'b00;
      checks++;
      if ({bus_oe, bus_dout, arr_we, arr_wdata} !== {eoe, edo, ewe, wdat}) begin
        errors++;
        $display("FAIL %s cycle %0d lat %0d: oe/dout/we/wdata actual %b/%h/%b/%h expected %b/%h/%b/%h",
                 rq, c, lat, bus_oe, bus_dout, arr_we, arr_wdata, eoe, edo, ewe, wdat);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b1; cfg_lat = 2'd1; rd_strb = 1'b0; wr_strb = 1'b0;
    halt_strb = 1'b0; byte_mask = 2'b00; arr_rdata = '0; bus_din = '0;
    #1 rst_n = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      rd_strb = 1'b1; arr_rdata = 16'hBEEF;
      #1;
      checks++;
      if (bus_oe !== 2'b00 || bus_dout !== 16'h0000) begin
        errors++;
        $display("FAIL R7 in reset: oe/dout actual %b/%h expected 00/0000", bus_oe, bus_dout);
      end
    end
    @(negedge clk);
    rd_strb = 1'b0; rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_latency();
    for (int l = 0; l < 4; l++) begin
      clear_stim();
      s_rd[1] = 1'b1; s_rd[5] = 1'b1; s_rd[6] = 1'b1; s_rd[10] = 1'b1;
      run_seq(12, 2'(l), "R1");
    end
  endtask

  task automatic t_stream();
    for (int l = 1; l < 4; l++) begin
      clear_stim();
      for (int i = 0; i < 12; i++) s_rd[i] = 1'b1;
      run_seq(12, 2'(l), "R2");
    end
  endtask

  task automatic t_rd_mask();
    clear_stim();
    for (int i = 0; i < 14; i++) s_rd[i] = 1'b1;
    s_mask[3] = 2'b01; s_mask[4] = 2'b10; s_mask[7] = 2'b11;
    s_mask[9] = 2'b10; s_mask[10] = 2'b10;
    run_seq(14, 2'd2, "R3");
    clear_stim();
    for (int i = 0; i < 8; i++) s_rd[i] = 1'b1;
    s_mask[0] = 2'b11; s_mask[5] = 2'b01;
    run_seq(8, 2'd3, "R3");
  endtask

  task automatic t_write();
    clear_stim();
    for (int i = 0; i < 4; i++) begin
      s_wr[i+1] = 1'b1; s_mask[i+1] = 2'(i);
    end
    s_mask[7] = 2'b11;
    run_seq(9, 2'd2, "R4");
  endtask

  task automatic t_turnaround();
    clear_stim();
    for (int i = 0; i < 5; i++) s_rd[i] = 1'b1;
    s_wr[5] = 1'b1; s_rd[5] = 1'b1; s_wr[6] = 1'b1;
    s_rd[8] = 1'b1;
    run_seq(10, 2'd3, "R5");
    clear_stim();
    s_rd[0] = 1'b1; s_rd[1] = 1'b1; s_wr[2] = 1'b1; s_rd[3] = 1'b1;
    run_seq(5, 2'd1, "R5");
  endtask

  task automatic t_halt();
    for (int l = 1; l < 4; l++) begin
      clear_stim();
      for (int i = 0; i < 10; i++) s_rd[i] = 1'b1;
      s_halt[6] = 1'b1;
      run_seq(7, 2'(l), "R6");
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    t_reset();
    t_latency();
    t_stream();
    t_rd_mask();
    t_write();
    t_turnaround();
    t_halt();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule